// File: doc/BRIEF.md
# Forward-phase byte sender for an extended-capability parallel port

This block is the host side of the forward transfer phase of an IEEE 1284 extended-capability link. Bytes arrive on a valid/ready stream. Each byte carries two flags. The first marks it as plain data or as a channel-address command. The second marks the final byte of a write. For every byte the block runs a four-edge handshake against the peripheral's acknowledge line, and then reports the outcome of the whole write.

Commands and data share the 8-bit bus, and the host acknowledge line tells the peripheral which one it is looking at. Two timeout budgets guard the handshake, and each failure mode has its own status code. Whatever the outcome, the strobe and acknowledge lines are back at their idle high level when the block reports.

Timeouts are measured in ticks of a free-running prescaler. The peripheral's acknowledge line passes through a two-flop synchroniser before the state machine uses it, so every response from the peripheral reaches the control logic two clock cycles late.

Top module: `ecp_fwd_tx`

## Requirements
- R1: For each byte, the byte is on `pd_out` at least one cycle before `host_clk` falls, and `pd_out` does not change until the handshake ends. On the success path, `host_clk` rises only after `periph_ack` has been seen high. A new falling edge of `host_clk` comes only after `periph_ack` has been seen low again.
- R2: A byte flagged as a command is sent with `host_ack` low for its whole handshake, and with bit 7 of `pd_out` forced to 1. Bits 6..0 are passed through unchanged.
- R3: A byte flagged as data is sent unchanged, with `host_ack` high.
- R4: A write that completes its byte flagged `in_last` ends with a one-cycle `done` pulse. At that pulse `status` is 2'b00 (ok) and `count` equals the number of bytes in the write.
- R5: Whenever `in_ready` is high, and in the cycle `done` is high, both `host_clk` and `host_ack` are high.
- R6: The wait for `periph_ack` high is bounded by TOTAL_TICKS ticks, counted from acceptance of the first byte of the write and not restarted per byte. When this limit runs out, `host_clk` is released and the write ends with `status` 2'b01 (busy timeout). `count` then holds the number of bytes completed. If the awaited level is present in the cycle the limit is reached, the wait succeeds instead.
- R7: The wait for `periph_ack` low is bounded by BYTE_TICKS ticks, restarted for every byte. When this limit runs out, the write ends with `status` 2'b10 (device error). `count` then holds the number of bytes completed, not counting the failed byte.
- R8: After reset, `pd_oe` is low, `host_clk` and `host_ack` are high, `in_ready` is high and `done` is low. `pd_oe` is high from the first accepted byte on, so it is high whenever `host_clk` is low.
- R9: Any failure closes the write. The next accepted byte starts a new write, and `count` restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Byte to send |
| in_is_cmd | input | 1 | 1: channel-address command, 0: data |
| in_last | input | 1 | Final byte of the write |
| periph_ack | input | 1 | Peripheral acknowledge (busy) line, asynchronous |
| pd_out | output | 8 | Parallel data bus value |
| pd_oe | output | 1 | Data bus output enable |
| host_clk | output | 1 | Host strobe, active low |
| host_ack | output | 1 | Host acknowledge, low marks a command |
| done | output | 1 | One-cycle end-of-write pulse |
| status | output | 2 | 00 ok, 01 busy timeout, 10 device error |
| count | output | CNT_W | Bytes completed in the current or last write |

## Verification
The hardest situation to reach is an expiry of the overall budget in which no single wait is long. The peripheral model answers every byte, but only after a long fixed delay. The write therefore runs out of budget partway through several successful bytes, and the check requires a busy status with a byte count strictly between zero and the write length. A second hard case is a failure on a later byte of a write. For this, the peripheral model is told to stop responding at a chosen byte index, either by never raising its line or by never dropping it. The bench then confirms that the reported count equals that index, and that the following write starts again from zero.

// File: rtl/ecp_fwd_pkg.sv
// Shared types for the forward-phase sender: result codes and controller states.
package ecp_fwd_pkg;
    typedef enum logic [1:0] {
        XS_OK      = 2'b00,
        XS_BUSY_TO = 2'b01,
        XS_DEV_ERR = 2'b10
    } xfer_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_SETUP,
        ST_WAIT_HI,
        ST_WAIT_LO
    } fwd_state_e;
endpackage

// File: rtl/ecp_sync2.sv
// Two-flop synchroniser for asynchronous peripheral status lines.
// Assumes each bit is independent; adds two cycles of latency.
module ecp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the line through two flops; reset value is the idle (low) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ecp_prescaler.sv
// Free-running prescaler: one-cycle tick every DIV clock cycles.
// Assumes DIV >= 1; DIV == 1 yields a tick every cycle.
module ecp_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] TOP = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Count 0..DIV-1 and wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)          cnt_q <= '0;
                else if (cnt_q == TOP) cnt_q <= '0;
                else                 cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/ecp_tick_timer.sv
// Saturating tick counter: expired is high once LIMIT ticks have been seen
// since the last clear. A clear takes priority over a tick.
module ecp_tick_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);
    logic [W-1:0] cnt_q;

    // Count ticks up to the limit and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         cnt_q <= '0;
        else if (tick && !expired) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM);

    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);  // R7
endmodule

// File: rtl/ecp_fwd_fsm.sv
// Per-byte handshake controller for the forward phase.
// Assumes ack_s is already synchronised and that the timers are cleared
// through total_clr / byte_clr one cycle before their expiry is used.
module ecp_fwd_fsm
    import ecp_fwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_is_cmd,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             ack_s,
    input  logic             total_exp,
    input  logic             byte_exp,
    output logic             total_clr,
    output logic             byte_clr,
    output logic [7:0]       pd_out,
    output logic             pd_oe,
    output logic             host_clk,
    output logic             host_ack,
    output logic             done,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] count
);
    fwd_state_e state_q;
    logic       last_q;
    logic       accept;

    assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_NEXT);
    assign accept    = in_valid && in_ready;
    assign total_clr = accept && (state_q == ST_IDLE);
    assign byte_clr  = (state_q == ST_WAIT_HI) && ack_s;

    // Handshake sequencing, line drive and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            last_q   <= 1'b0;
            pd_out   <= '0;
            pd_oe    <= 1'b0;
            host_clk <= 1'b1;
            host_ack <= 1'b1;
            done     <= 1'b0;
            status   <= XS_OK;
            count    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_NEXT: begin
                    if (accept) begin
                        pd_out   <= in_is_cmd ? {1'b1, in_byte[6:0]} : in_byte;
                        host_ack <= !in_is_cmd;
                        last_q   <= in_last;
                        pd_oe    <= 1'b1;
                        if (state_q == ST_IDLE) count <= '0;
                        state_q  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    host_clk <= 1'b0;
                    state_q  <= ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (ack_s) begin
                        host_clk <= 1'b1;
                        state_q  <= ST_WAIT_LO;
                    end else if (total_exp) begin
                        host_clk <= 1'b1;
                        host_ack <= 1'b1;
                        done     <= 1'b1;
                        status   <= XS_BUSY_TO;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (!ack_s) begin
                        count    <= count + 1'b1;
                        host_ack <= 1'b1;
                        if (last_q) begin
                            done    <= 1'b1;
                            status  <= XS_OK;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_NEXT;
                        end
                    end else if (byte_exp) begin
                        host_ack <= 1'b1;
                        done     <= 1'b1;
                        status   <= XS_DEV_ERR;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI || state_q == ST_WAIT_LO) |-> $stable(pd_out));  // R1
    AST_RISE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_clk) && !done) |-> $past(ack_s));  // R1
    AST_CMD_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !host_ack) |-> pd_out[7]);  // R2
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready || done) |-> (host_clk && host_ack));  // R5
    AST_SEEN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI && ack_s) |=> !(done && status == XS_BUSY_TO));  // R6
    AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clk |-> pd_oe);  // R8
endmodule

// File: rtl/ecp_fwd_tx.sv
// Forward-phase byte sender top: synchroniser, prescaler, overall and
// per-byte timers, and the handshake controller.
// Assumes periph_ack is asynchronous and low when the peripheral is idle.
module ecp_fwd_tx #(
    parameter int PRESCALE    = 50,
    parameter int TOTAL_TICKS = 1000,
    parameter int BYTE_TICKS  = 35,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    input  logic             in_is_cmd,
    input  logic             in_last,
    input  logic             periph_ack,
    output logic [7:0]       pd_out,
    output logic             pd_oe,
    output logic             host_clk,
    output logic             host_ack,
    output logic             done,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] count
);
    logic ack_s, tick, total_clr, byte_clr, total_exp, byte_exp;

    ecp_sync2 #(.W(1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(periph_ack), .q(ack_s));

    ecp_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    ecp_tick_timer #(.LIMIT(TOTAL_TICKS)) u_total (
        .clk(clk), .rst_n(rst_n), .clr(total_clr), .tick(tick), .expired(total_exp));

    ecp_tick_timer #(.LIMIT(BYTE_TICKS)) u_byte (
        .clk(clk), .rst_n(rst_n), .clr(byte_clr), .tick(tick), .expired(byte_exp));

    ecp_fwd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_is_cmd(in_is_cmd),
        .in_last(in_last), .in_ready(in_ready),
        .ack_s(ack_s), .total_exp(total_exp), .byte_exp(byte_exp),
        .total_clr(total_clr), .byte_clr(byte_clr),
        .pd_out(pd_out), .pd_oe(pd_oe), .host_clk(host_clk), .host_ack(host_ack),
        .done(done), .status(status), .count(count));
endmodule

// File: tb/ecp_fwd_tx_tb.sv
// Self-checking bench: random writes plus directed failure cases, checked
// against a peripheral model and expected values computed here.
module ecp_fwd_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_byte = '0;
    logic             in_is_cmd = 1'b0;
    logic             in_last = 1'b0;
    logic             periph_ack = 1'b0;
    logic [7:0]       pd_out;
    logic             pd_oe, host_clk, host_ack, done;
    logic [1:0]       status;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Stimulus buffers and peripheral-side capture.
    logic [7:0] wr_b [0:63];
    logic       wr_c [0:63];
    logic [7:0] cap_d [0:63];
    logic       cap_a [0:63];
    int  p_idx = 0;
    int  norise_at = -1;
    int  stuck_at = -1;
    int  hi_fix = -1;
    logic release_stuck = 1'b0;

    logic       done_seen = 1'b0;
    logic [1:0] got_st = '0;
    int         got_cnt = 0;

    ecp_fwd_tx #(.PRESCALE(4), .TOTAL_TICKS(64), .BYTE_TICKS(8), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_cmd(in_is_cmd), .in_last(in_last),
        .periph_ack(periph_ack), .pd_out(pd_out), .pd_oe(pd_oe),
        .host_clk(host_clk), .host_ack(host_ack), .done(done),
        .status(status), .count(count));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic cmd);
        return cmd ? (b | 8'h80) : b;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Record the end-of-write report.
    always @(negedge clk) begin
        if (done) begin
            done_seen = 1'b1;
            got_st    = status;
            got_cnt   = int'(count);
        end
    end

    // Peripheral model: answers each strobe with configurable delays.
    initial begin
        forever begin
            int idx;
            int d;
            @(negedge host_clk);
            idx = p_idx;
            p_idx++;
            if (idx < 64) begin
                cap_d[idx] = pd_out;
                cap_a[idx] = host_ack;
            end
            chk(pd_oe == 1'b1, "R8 bus enabled at strobe", int'(pd_oe), 1);
            chk(periph_ack == 1'b0, "R1 strobe only after ack low", int'(periph_ack), 0);
            if (idx != norise_at) begin
                d = (hi_fix >= 0) ? hi_fix : int'($urandom % 7);
                repeat (d + 1) @(negedge clk);
                periph_ack = 1'b1;
                @(posedge host_clk);
                chk(periph_ack == 1'b1, "R1 strobe release after ack high", int'(periph_ack), 1);
                if (idx == stuck_at) begin
                    wait (release_stuck);
                    periph_ack = 1'b0;
                end else begin
                    d = int'($urandom % 7);
                    repeat (d + 1) @(negedge clk);
                    periph_ack = 1'b0;
                end
            end
        end
    end

    // Push n bytes from the buffers, stop on an early report, wait for done.
    task automatic run_write(input int n);
        int guard;
        done_seen = 1'b0;
        p_idx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready && !done) @(negedge clk);
            if (done || done_seen) break;
            in_valid  = 1'b1;
            in_byte   = wr_b[i];
            in_is_cmd = wr_c[i];
            in_last   = (i == n - 1);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        guard = 0;
        while (!done_seen && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_seen, "R4 write reported", int'(done_seen), 1);
        chk(host_clk && host_ack, "R5 idle lines after report",
            int'({host_clk, host_ack}), 3);
    endtask

    task automatic check_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            if (wr_c[i]) begin
                chk(cap_d[i] == exp_byte(wr_b[i], 1'b1), "R2 command byte",
                    int'(cap_d[i]), int'(exp_byte(wr_b[i], 1'b1)));
                chk(cap_a[i] == 1'b0, "R2 command marked", int'(cap_a[i]), 0);
            end else begin
                chk(cap_d[i] == wr_b[i], "R3 data byte", int'(cap_d[i]), int'(wr_b[i]));
                chk(cap_a[i] == 1'b1, "R3 data ack high", int'(cap_a[i]), 1);
            end
        end
    endtask

    task automatic normal_mode();
        norise_at = -1;
        stuck_at = -1;
        hi_fix = -1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(pd_oe == 1'b0, "R8 oe low after reset", int'(pd_oe), 0);
        chk(host_clk && host_ack, "R8 lines high after reset", int'({host_clk, host_ack}), 3);
        chk(in_ready == 1'b1 && done == 1'b0, "R8 ready and no done after reset",
            int'({in_ready, done}), 2);
        rst_n = 1'b1;

        // Directed: command with bit 7 clear, then data 0xFF and 0x00
        normal_mode();
        wr_b[0] = 8'h05; wr_c[0] = 1'b1;
        wr_b[1] = 8'hFF; wr_c[1] = 1'b0;
        wr_b[2] = 8'h00; wr_c[2] = 1'b0;
        wr_b[3] = 8'hFF; wr_c[3] = 1'b1;
        run_write(4);
        chk(got_st == 2'b00, "R4 status ok", int'(got_st), 0);
        chk(got_cnt == 4, "R4 count", got_cnt, 4);
        check_bytes(4);
        chk(pd_oe == 1'b1, "R8 oe stays high", int'(pd_oe), 1);

        // Random writes of mixed commands and data
        for (int w = 0; w < 20; w++) begin
            int n;
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) begin
                wr_b[i] = 8'($urandom);
                wr_c[i] = ($urandom % 4) == 0;
            end
            run_write(n);
            chk(got_st == 2'b00, "R4 random status ok", int'(got_st), 0);
            chk(got_cnt == n, "R4 random count", got_cnt, n);
            check_bytes(n);
        end

        // Busy timeout: peripheral never raises its line on byte 1
        for (int i = 0; i < 3; i++) begin wr_b[i] = 8'(8'h40 + i); wr_c[i] = 1'b0; end
        norise_at = 1;
        run_write(3);
        chk(got_st == 2'b01, "R6 busy timeout status", int'(got_st), 1);
        chk(got_cnt == 1, "R6 completed count", got_cnt, 1);
        normal_mode();

        // R9: next write after a failure starts a fresh count
        run_write(2);
        chk(got_st == 2'b00, "R9 ok after failure", int'(got_st), 0);
        chk(got_cnt == 2, "R9 count restarts", got_cnt, 2);

        // Device error: peripheral holds its line high on byte 2
        for (int i = 0; i < 4; i++) begin wr_b[i] = 8'(8'h10 + i); wr_c[i] = (i == 0); end
        stuck_at = 2;
        run_write(4);
        chk(got_st == 2'b10, "R7 device error status", int'(got_st), 2);
        chk(got_cnt == 2, "R7 completed count", got_cnt, 2);
        release_stuck = 1'b1;
        repeat (5) @(negedge clk);
        release_stuck = 1'b0;
        normal_mode();
        run_write(1);
        chk(got_st == 2'b00 && got_cnt == 1, "R9 recovery after device error",
            got_cnt, 1);

        // Overall budget: every byte answered slowly, budget spans bytes
        for (int i = 0; i < 8; i++) begin wr_b[i] = 8'(i * 3); wr_c[i] = 1'b0; end
        hi_fix = 45;
        run_write(1);
        chk(got_st == 2'b00, "R6 single slow byte within budget", int'(got_st), 0);
        run_write(8);
        chk(got_st == 2'b01, "R6 overall budget not restarted per byte", int'(got_st), 1);
        chk(got_cnt >= 1 && got_cnt < 8, "R6 partial count", got_cnt, 4);
        normal_mode();
        repeat (20) @(negedge clk);

        finish_run();
    end
endmodule